// File: doc/BRIEF.md
# USB Endpoint Transfer Descriptor Packetizer

This block takes one endpoint transfer descriptor and turns it into a sequence of bus packets. A single start strobe latches the descriptor. The descriptor holds a byte count, the starting offset inside the first buffer page, five page-aligned buffer base pointers, the endpoint's maximum packet size, a packets-per-frame multiplier, a high-bandwidth select and a zero-length-termination enable. For each packet the block announces the length and the data PID. It then streams one byte address per cycle, and the addresses step from one page into the next.

The link layer returns a pass or fail verdict for every packet. A pass retires the bytes that were moved and moves the data PID on. A fail leaves the count and the byte cursor where they were, so the same packet is issued again. When nothing is left, the block raises a one-cycle completion pulse. A descriptor that is too large or has a zero packet size is refused at load. A cursor that would need a sixth page stops the transfer with an overrun flag.

Top module: `usb_td_packetizer`

## Requirements
- R1: After a synchronous reset, busy, done, pkt_valid, addr_valid, err_size and err_overrun are all low.
- R2: A start with a byte count above PAGES times the page size, or with a maximum packet size of zero, sets err_size on the next cycle and issues no packet. err_size stays high until the next start, and busy stays low.
- R3: A start with a byte count of zero and zlt_en high pulses done on the next cycle and issues no packet. With zlt_en low it issues exactly one zero-length packet, whose PID is DATA0.
- R4: Each announced packet length equals the smaller of the remaining count and the maximum packet size.
- R5: The byte address is the upper bits of the current page pointer joined with the in-page offset. The first page starts at first_off. When the offset passes the last byte of a page, the cursor moves to the next page at offset zero.
- R6: A pass verdict lowers remaining by the packet length. A fail verdict leaves remaining and the byte cursor unchanged, and the same packet is issued again with the same length, PID and addresses.
- R7: With hi_bw low, the PID starts at DATA0 for each descriptor and toggles between DATA0 and DATA1 after every pass. The codes are DATA0 = 0, DATA1 = 1 and DATA2 = 2.
- R8: With hi_bw high, each frame carries n = min(mult, ceil(remaining / max_pkt)) packets, where mult 0 counts as 1 and n is computed when the frame starts. The frame's PIDs run from code n-1 down to DATA0, and the next frame starts after the DATA0 packet passes.
- R9: If a byte would fall in a sixth page, no address is emitted for it. On the next cycle err_overrun rises, busy falls, and done does not pulse.
- R10: busy is high from the cycle after an accepted start until the cycle in which done pulses. done pulses once, in the cycle after the pass that brings remaining to zero.
- R11: pkt_valid is high for a single cycle. It is followed at once by exactly pkt_len cycles of addr_valid. A verdict is taken only after the last address of the packet.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latches the descriptor fields when idle |
| total_bytes | input | CNT_W | Byte count of the descriptor |
| first_off | input | PAGE_BITS | Starting offset in the first page |
| page_ptrs | input | PAGES*PTR_W | Page-aligned base pointers, page 0 in the low bits |
| max_pkt | input | MPL_W | Maximum packet size |
| mult | input | 2 | Packets per frame in high-bandwidth mode |
| hi_bw | input | 1 | Selects high-bandwidth PID sequencing |
| zlt_en | input | 1 | Suppresses the zero-length packet for an empty descriptor |
| result_valid | input | 1 | A verdict for the current packet is present |
| result_ok | input | 1 | The verdict is pass (1) or fail (0) |
| pkt_valid | output | 1 | A packet is announced this cycle |
| pkt_len | output | MPL_W | Length of the announced packet |
| pkt_pid | output | 2 | Data PID code of the packet |
| addr_valid | output | 1 | addr holds a packet byte address |
| addr | output | PTR_W | Byte address |
| remaining | output | CNT_W | Bytes not yet retired |
| busy | output | 1 | A descriptor is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_size | output | 1 | The descriptor was refused at load |
| err_overrun | output | 1 | The transfer needed a sixth page |

## Verification
The hardest state to reach from the ports is the sixth-page overrun. With 4 KB pages it takes over sixteen thousand streamed bytes. The bench therefore builds the block with 16-byte pages, where a descriptor with a nonzero first offset and a count near the five-page limit runs off the end within a few dozen cycles. The bench sweeps every legal count at two offsets, two packet sizes and both PID modes. Periodic fail verdicts force retries at every position, including retries right after a page crossing.

// File: rtl/usb_td_pkg.sv
package usb_td_pkg;
   typedef enum logic [1:0] {
      PID_DATA0 = 2'd0,
      PID_DATA1 = 2'd1,
      PID_DATA2 = 2'd2
   } data_pid_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_STREAM,
      ST_WAIT
   } td_state_e;
endpackage

// File: rtl/td_addr_gen.sv
module td_addr_gen #(
   parameter int PAGES     = 5,
   parameter int PAGE_BITS = 12,
   parameter int PTR_W     = 32
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load,
   input  logic [PAGE_BITS-1:0]   load_off,
   input  logic                   step,
   input  logic                   commit,
   input  logic                   restore,
   input  logic [PAGES*PTR_W-1:0] page_ptrs,
   output logic [PTR_W-1:0]       addr,
   output logic                   beyond
);
   localparam int PG_W = $clog2(PAGES + 1);

   logic [PTR_W-1:0]     ptr_arr [PAGES];
   logic [PG_W-1:0]      pg, pg_s;
   logic [PAGE_BITS-1:0] off, off_s;
   logic [PTR_W-1:0]     base;

   for (genvar i = 0; i < PAGES; i++) begin : g_unpack
      assign ptr_arr[i] = page_ptrs[i*PTR_W +: PTR_W];
   end

   always_comb begin
      base = '0;
      for (int i = 0; i < PAGES; i++)
         if (pg == PG_W'(i)) base = ptr_arr[i];
   end

   assign addr   = {base[PTR_W-1:PAGE_BITS], off};
   assign beyond = (pg >= PG_W'(PAGES));

   always_ff @(posedge clk) begin
      if (rst) begin
         pg    <= '0;
         off   <= '0;
         pg_s  <= '0;
         off_s <= '0;
      end else if (load) begin
         pg    <= '0;
         off   <= load_off;
         pg_s  <= '0;
         off_s <= load_off;
      end else if (restore) begin
         pg  <= pg_s;
         off <= off_s;
      end else begin
         if (step) begin
            off <= off + PAGE_BITS'(1);
            if (&off) pg <= pg + PG_W'(1);
         end
         if (commit) begin
            pg_s  <= pg;
            off_s <= off;
         end
      end
   end

   // R9
   no_sixth_page_chk: assert property (@(posedge clk) disable iff (rst)
      step |-> !beyond);
endmodule

// File: rtl/td_pid_seq.sv
module td_pid_seq
   import usb_td_pkg::*;
#(
   parameter int CNT_W = 15,
   parameter int MPL_W = 11
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init,
   input  logic             hb_in,
   input  logic [1:0]       mult_in,
   input  logic [CNT_W-1:0] rem_eval,
   input  logic [MPL_W-1:0] max_pkt,
   input  logic             adv,
   output data_pid_e        pid
);
   localparam int XW = ((CNT_W > MPL_W) ? CNT_W : MPL_W) + 2;

   logic       hb_q;
   logic [1:0] mult_q;
   logic [1:0] left;
   logic       tog;

   function automatic logic [1:0] frame_count(input logic [CNT_W-1:0] r,
                                              input logic [MPL_W-1:0] m,
                                              input logic [1:0]       k);
      logic [XW-1:0] rx, mx;
      rx = XW'(r);
      mx = XW'(m);
      frame_count = 2'd1;
      if (k >= 2'd2 && rx > mx)        frame_count = 2'd2;
      if (k == 2'd3 && rx > (mx << 1)) frame_count = 2'd3;
   endfunction

   always_ff @(posedge clk) begin
      if (rst) begin
         hb_q   <= 1'b0;
         mult_q <= 2'd1;
         left   <= 2'd1;
         tog    <= 1'b0;
      end else if (init) begin
         hb_q   <= hb_in;
         mult_q <= mult_in;
         left   <= frame_count(rem_eval, max_pkt, mult_in);
         tog    <= 1'b0;
      end else if (adv) begin
         tog <= ~tog;
         if (left == 2'd1) left <= frame_count(rem_eval, max_pkt, mult_q);
         else              left <= left - 2'd1;
      end
   end

   assign pid = hb_q ? data_pid_e'(left - 2'd1) : data_pid_e'({1'b0, tog});

   // R8
   hb_countdown_chk: assert property (@(posedge clk) disable iff (rst)
      (hb_q && adv && !init && pid != PID_DATA0) |=> pid == data_pid_e'($past(pid) - 2'd1));
   // R7
   bulk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (!hb_q && adv && !init) |=> pid != $past(pid));
endmodule

// File: rtl/usb_td_packetizer.sv
module usb_td_packetizer
   import usb_td_pkg::*;
#(
   parameter int PAGES     = 5,
   parameter int PAGE_BITS = 12,
   parameter int PTR_W     = 32,
   parameter int CNT_W     = 15,
   parameter int MPL_W     = 11
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [CNT_W-1:0]       total_bytes,
   input  logic [PAGE_BITS-1:0]   first_off,
   input  logic [PAGES*PTR_W-1:0] page_ptrs,
   input  logic [MPL_W-1:0]       max_pkt,
   input  logic [1:0]             mult,
   input  logic                   hi_bw,
   input  logic                   zlt_en,
   input  logic                   result_valid,
   input  logic                   result_ok,
   output logic                   pkt_valid,
   output logic [MPL_W-1:0]       pkt_len,
   output logic [1:0]             pkt_pid,
   output logic                   addr_valid,
   output logic [PTR_W-1:0]       addr,
   output logic [CNT_W-1:0]       remaining,
   output logic                   busy,
   output logic                   done,
   output logic                   err_size,
   output logic                   err_overrun
);
   localparam int MAX_BYTES = PAGES << PAGE_BITS;
   localparam int XW        = ((CNT_W > MPL_W) ? CNT_W : MPL_W) + 1;

   if (PAGES < 1) begin : g_bad_pages
      $error("PAGES must be at least 1");
   end
   if (PTR_W <= PAGE_BITS) begin : g_bad_ptr
      $error("PTR_W must exceed PAGE_BITS");
   end
   if (CNT_W < $clog2(MAX_BYTES + 1)) begin : g_bad_cnt
      $error("CNT_W too narrow for the page limit");
   end

   td_state_e        state;
   logic [CNT_W-1:0] rem;
   logic [MPL_W-1:0] max_q;
   logic [MPL_W-1:0] bcnt;
   logic             busy_q, done_q, esz_q, eov_q;

   logic [XW-1:0]    rem_x, max_x, len_x;
   logic [CNT_W-1:0] rem_after, rem_eval;
   logic             bad_load, accept, pass, fail, beyond, step;
   data_pid_e        pid_w;

   assign rem_x     = XW'(rem);
   assign max_x     = XW'(max_q);
   assign len_x     = (rem_x < max_x) ? rem_x : max_x;
   assign pkt_len   = len_x[MPL_W-1:0];
   assign rem_after = rem - len_x[CNT_W-1:0];

   assign bad_load = ({1'b0, total_bytes} > (CNT_W+1)'(MAX_BYTES)) || (max_pkt == '0);
   assign accept   = (state == ST_IDLE) && start;
   assign pass     = (state == ST_WAIT) && result_valid && result_ok;
   assign fail     = (state == ST_WAIT) && result_valid && !result_ok;
   assign rem_eval = (state == ST_IDLE) ? total_bytes : rem_after;

   assign pkt_valid  = (state == ST_ISSUE);
   assign step       = (state == ST_STREAM) && !beyond;
   assign addr_valid = step;

   td_addr_gen #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS), .PTR_W(PTR_W)) u_agen (
      .clk(clk), .rst(rst), .load(accept), .load_off(first_off), .step(step),
      .commit(pass), .restore(fail), .page_ptrs(page_ptrs), .addr(addr),
      .beyond(beyond));

   td_pid_seq #(.CNT_W(CNT_W), .MPL_W(MPL_W)) u_pid (
      .clk(clk), .rst(rst), .init(accept), .hb_in(hi_bw), .mult_in(mult),
      .rem_eval(rem_eval), .max_pkt(max_pkt), .adv(pass), .pid(pid_w));

   assign pkt_pid = pid_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         rem    <= '0;
         max_q  <= '0;
         bcnt   <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         esz_q  <= 1'b0;
         eov_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               esz_q <= 1'b0;
               eov_q <= 1'b0;
               rem   <= total_bytes;
               max_q <= max_pkt;
               if (bad_load) begin
                  esz_q <= 1'b1;
               end else if (total_bytes == '0 && zlt_en) begin
                  done_q <= 1'b1;
               end else begin
                  busy_q <= 1'b1;
                  state  <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               bcnt  <= '0;
               state <= (pkt_len == '0) ? ST_WAIT : ST_STREAM;
            end
            ST_STREAM: begin
               if (beyond) begin
                  eov_q  <= 1'b1;
                  busy_q <= 1'b0;
                  state  <= ST_IDLE;
               end else if ((bcnt + MPL_W'(1)) == pkt_len) begin
                  state <= ST_WAIT;
               end else begin
                  bcnt <= bcnt + MPL_W'(1);
               end
            end
            ST_WAIT: begin
               if (pass) begin
                  rem <= rem_after;
                  if (rem_after == '0) begin
                     done_q <= 1'b1;
                     busy_q <= 1'b0;
                     state  <= ST_IDLE;
                  end else begin
                     state <= ST_ISSUE;
                  end
               end else if (fail) begin
                  state <= ST_ISSUE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign remaining   = rem;
   assign busy        = busy_q;
   assign done        = done_q;
   assign err_size    = esz_q;
   assign err_overrun = eov_q;

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);
   // R10
   busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> (done || err_overrun));
   // R6
   fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
      fail |=> remaining == $past(remaining));
   // R4
   len_bound_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_valid |-> (XW'(pkt_len) <= XW'(max_q)) && (XW'(pkt_len) <= XW'(remaining)));
   // R2
   refused_idle_chk: assert property (@(posedge clk) disable iff (rst)
      err_size |-> (!busy && !pkt_valid));
   // R11
   issue_once_chk: assert property (@(posedge clk) disable iff (rst)
      pkt_valid |=> !pkt_valid);
endmodule

// File: tb/usb_td_packetizer_test.sv
module usb_td_packetizer_test;
   localparam int PB = 4;
   localparam int NP = 5;
   localparam int PW = 16;
   localparam int CW = 7;
   localparam int MW = 5;
   localparam int LIMIT = NP << PB;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start = 1'b0;
   logic [CW-1:0]    total_bytes = '0;
   logic [PB-1:0]    first_off = '0;
   logic [NP*PW-1:0] page_ptrs;
   logic [MW-1:0]    max_pkt = '0;
   logic [1:0]       mult = '0;
   logic             hi_bw = 1'b0, zlt_en = 1'b0;
   logic             result_valid = 1'b0, result_ok = 1'b0;
   logic             pkt_valid, addr_valid, busy, done, err_size, err_overrun;
   logic [MW-1:0]    pkt_len;
   logic [1:0]       pkt_pid;
   logic [PW-1:0]    addr;
   logic [CW-1:0]    remaining;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   usb_td_packetizer #(.PAGES(NP), .PAGE_BITS(PB), .PTR_W(PW), .CNT_W(CW), .MPL_W(MW)) uut (
      .clk(clk), .rst(rst), .start(start), .total_bytes(total_bytes),
      .first_off(first_off), .page_ptrs(page_ptrs), .max_pkt(max_pkt), .mult(mult),
      .hi_bw(hi_bw), .zlt_en(zlt_en), .result_valid(result_valid), .result_ok(result_ok),
      .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_pid(pkt_pid), .addr_valid(addr_valid),
      .addr(addr), .remaining(remaining), .busy(busy), .done(done),
      .err_size(err_size), .err_overrun(err_overrun));

   always #4 clk = ~clk;

   function automatic int pbase(int i);
      return 'h0A00 + i * 'h130;
   endfunction

   function automatic int frame_n(int r, int m, int k);
      int kk = (k == 0) ? 1 : k;
      int c  = (r + m - 1) / m;
      if (c == 0) c = 1;
      return (c < kk) ? c : kk;
   endfunction

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < NP; i++) page_ptrs[i*PW +: PW] = PW'(pbase(i));
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            summary();
         end
      end
   end

   task automatic run_xfer(int total, int off, int maxp, int k, bit hb, bit zlt, int fper);
      int rem, pos, pos_s, left, tog, attempt, elen;
      bit ok;
      @(negedge clk);
      total_bytes = CW'(total); first_off = PB'(off); max_pkt = MW'(maxp);
      mult = 2'(k); hi_bw = hb; zlt_en = zlt; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (total > LIMIT || maxp == 0) begin
         chk("R2 err_size", err_size, 1);
         chk("R2 busy", busy, 0);
         @(negedge clk);
         chk("R2 no packet", pkt_valid, 0);
         chk("R2 err_size held", err_size, 1);
         return;
      end
      if (total == 0 && zlt) begin
         chk("R3 zlt done", done, 1);
         chk("R3 zlt busy", busy, 0);
         @(negedge clk);
         chk("R3 zlt no packet", pkt_valid, 0);
         return;
      end
      chk("R10 busy after start", busy, 1);
      chk("R2 errors cleared", err_size | err_overrun, 0);
      rem = total; pos = off; pos_s = off; tog = 0; attempt = 0;
      left = frame_n(rem, maxp, k);
      forever begin
         elen = (rem < maxp) ? rem : maxp;
         chk("R11 pkt_valid", pkt_valid, 1);
         chk("R4 pkt_len", pkt_len, elen);
         if (hb) chk("R8 hb pid", pkt_pid, left - 1);
         else    chk("R7 bulk pid", pkt_pid, tog);
         @(negedge clk);
         for (int b = 0; b < elen; b++) begin
            if ((pos >> PB) >= NP) begin
               chk("R9 no address past pages", addr_valid, 0);
               @(negedge clk);
               chk("R9 err_overrun", err_overrun, 1);
               chk("R9 busy low", busy, 0);
               chk("R9 no done", done, 0);
               return;
            end
            chk("R11 addr_valid", addr_valid, 1);
            chk("R5 address", addr, pbase(pos >> PB) | (pos & ((1 << PB) - 1)));
            pos++;
            @(negedge clk);
         end
         chk("R11 stream length", addr_valid, 0);
         attempt++;
         ok = (fper == 0) || (attempt % fper != 0);
         result_valid = 1'b1; result_ok = ok;
         @(negedge clk);
         result_valid = 1'b0;
         if (ok) begin
            rem = rem - elen; pos_s = pos; tog ^= 1;
            if (left == 1) left = frame_n(rem, maxp, k);
            else           left--;
         end else begin
            pos = pos_s;
         end
         chk("R6 remaining", remaining, rem);
         if (ok && rem == 0) begin
            chk("R10 done pulse", done, 1);
            chk("R10 busy end", busy, 0);
            @(negedge clk);
            chk("R10 single pulse", done, 0);
            return;
         end
         chk("R10 no early done", done, 0);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 pkt_valid", pkt_valid, 0);
      chk("R1 addr_valid", addr_valid, 0);
      chk("R1 errors", err_size | err_overrun, 0);

      run_xfer(LIMIT + 1, 0, 8, 1, 1'b0, 1'b0, 0);
      run_xfer(127, 3, 8, 1, 1'b1, 1'b0, 0);
      run_xfer(10, 0, 0, 1, 1'b0, 1'b0, 0);
      run_xfer(0, 0, 8, 1, 1'b0, 1'b1, 0);
      run_xfer(0, 0, 8, 3, 1'b1, 1'b0, 0);
      run_xfer(0, 0, 8, 1, 1'b0, 1'b0, 2);
      run_xfer(15, 0, 8, 3, 1'b1, 1'b0, 0);
      run_xfer(LIMIT, 0, 16, 3, 1'b1, 1'b0, 0);
      run_xfer(LIMIT, 9, 16, 1, 1'b0, 1'b0, 3);

      for (int t = 0; t <= LIMIT; t++) begin
         for (int o = 0; o < 2; o++) begin
            for (int mi = 0; mi < 2; mi++) begin
               for (int hb = 0; hb < 2; hb++) begin
                  run_xfer(t, o * 7, (mi == 0) ? 3 : 8, (t % 4), hb[0], t[0],
                           (t % 3 == 0) ? 3 : ((t % 3 == 1) ? 0 : 5));
               end
            end
         end
      end
      summary();
   end
endmodule